// File: doc/BRIEF.md
# Leaf rule range matcher

This block finishes a decision-tree packet classifier. After the tree walk has narrowed each tree's search down to a single leaf, the block receives the packet's five header fields and, for each tree, the address of that leaf and a flag telling whether the walk for that tree is still alive. For each tree it reads the leaf word, then fetches the leaf's rule records from a shared synchronous RAM and checks the packet against the inclusive range that each rule gives for every header field. It then reports one answer for the packet: the lowest-numbered matching rule across all trees, or a no-match code.

Rule records are packed in pairs, with two 208-bit rules stored in three RAM words. A leaf names two such pairs, so serving one leaf always costs one leaf read and six rule reads. A tree whose walk was rejected early still spends its full slot and reports no match. Because of this, the latency never depends on the packet or on the table contents. The trees share one RAM port and are served one after another, ten cycles each. The RAM is loaded through a plain write port while the block is idle.

Top module: `leaf_range_matcher`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy`, `done` and `hit` are 0 and `rule_idx` is all ones.
- R2: A rule matches only when every key field lies within that rule's inclusive [lo, hi] range. Source and destination address, source and destination port and protocol are all checked, and a value one step outside either bound of any field rejects the rule.
- R3: A leaf word carries, from bit 0 upward: a 2-bit node type, a 3-bit rule count, the first pair number (PAIR_W bits) and the second pair number (PAIR_W bits). Only type 2'b11 is a leaf; any other type gives no match for that tree. Slots 0 and 1 are rules 2·first and 2·first+1, and slots 2 and 3 are rules 2·second and 2·second+1.
- R4: Only slots whose number is below the rule count take part in matching. A count of 0 gives no match, and a count above 4 is treated as 4.
- R5: Pair p occupies words RULE_BASE+3p to RULE_BASE+3p+2. The first of these words holds the least significant bits of the 416-bit pair value. The even rule sits in the low 208 bits and the odd rule in the high 208 bits. Within a rule, from the MSB down, the fields are: source address lo and hi, destination address lo and hi, source port lo and hi, destination port lo and hi, protocol lo and hi.
- R6: Within a leaf, the matching rule with the lowest index wins, whatever slot it occupies.
- R7: The final answer is the lowest matching rule index over all trees. A tree whose `tree_live` bit is 0 contributes no match, whatever its leaf holds.
- R8: With no match anywhere, `hit` is 0 and `rule_idx` is all ones.
- R9: `done` rises exactly 10·NUM_TREES clock edges after the edge that accepts `start`, whatever the key, the leaf contents or the live mask. `busy` is high in between.
- R10: While `busy` is high, `start`, the key, the leaf addresses and the live mask are ignored. A new `start` gives no additional `done`, and the result in progress is unchanged.
- R11: `done` is a single-cycle pulse, and `hit` and `rule_idx` hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | RAM write enable |
| wr_addr | input | ADDR_W | RAM write address |
| wr_data | input | WORD_W (139) | RAM write data |
| start | input | 1 | Begin a lookup (taken only when idle) |
| key_src_ip | input | 32 | Packet source address |
| key_dst_ip | input | 32 | Packet destination address |
| key_src_port | input | 16 | Packet source port |
| key_dst_port | input | 16 | Packet destination port |
| key_proto | input | 8 | Packet protocol |
| leaf_addr | input | NUM_TREES·ADDR_W | Leaf word address per tree, tree 0 in the low bits |
| tree_live | input | NUM_TREES | 1 when the tree walk reached its leaf alive |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | A rule matched |
| rule_idx | output | PAIR_W+1 | Winning rule index, all ones on no match |

## Verification
A bad step counter or tree counter shows up at the very first lookup as a `done` strobe that arrives at the wrong edge, because the latency is fixed. A bad leaf capture or a bad pair assembly shows up on that same strobe as a wrong index or a wrong hit flag. The leaves used for this mix swapped pair order, partial counts, boundary-exact rules and each field failing on its own. Errors in the running best-so-far state only appear when several live trees disagree, so the multi-tree cases vary the live mask and the order of the winning indices. The ignored-start case watches for a second strobe.

// File: rtl/lrm_pkg.sv
package lrm_pkg;

  localparam int IP_W    = 32;
  localparam int PORT_W  = 16;
  localparam int PROTO_W = 8;

  // one rule: lo/hi per header field
  localparam int RULE_W  = 2 * (2 * IP_W + 2 * PORT_W + PROTO_W);
  localparam int PAIR_BITS = 2 * RULE_W;
  // two rules fit in three memory words
  localparam int WORD_W  = (PAIR_BITS + 2) / 3;
  localparam int SLOTS   = 4;

  localparam logic [1:0] LEAF_TYPE = 2'b11;

  typedef struct packed {
    logic [IP_W-1:0]    sip_lo;
    logic [IP_W-1:0]    sip_hi;
    logic [IP_W-1:0]    dip_lo;
    logic [IP_W-1:0]    dip_hi;
    logic [PORT_W-1:0]  sp_lo;
    logic [PORT_W-1:0]  sp_hi;
    logic [PORT_W-1:0]  dp_lo;
    logic [PORT_W-1:0]  dp_hi;
    logic [PROTO_W-1:0] pr_lo;
    logic [PROTO_W-1:0] pr_hi;
  } rule_t;

  typedef struct packed {
    logic [IP_W-1:0]    sip;
    logic [IP_W-1:0]    dip;
    logic [PORT_W-1:0]  sp;
    logic [PORT_W-1:0]  dp;
    logic [PROTO_W-1:0] pr;
  } key_t;

endpackage

// File: rtl/lrm_ram.sv
module lrm_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 139
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // registered read, one cycle latency
  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/lrm_rule_cmp.sv
module lrm_rule_cmp
  import lrm_pkg::*;
(
  input  key_t  key,
  input  rule_t rule,
  output logic  match
);

  logic [4:0] in_rng;

  always_comb begin
    in_rng[0] = (key.sip >= rule.sip_lo) && (key.sip <= rule.sip_hi);
    in_rng[1] = (key.dip >= rule.dip_lo) && (key.dip <= rule.dip_hi);
    in_rng[2] = (key.sp  >= rule.sp_lo)  && (key.sp  <= rule.sp_hi);
    in_rng[3] = (key.dp  >= rule.dp_lo)  && (key.dp  <= rule.dp_hi);
    in_rng[4] = (key.pr  >= rule.pr_lo)  && (key.pr  <= rule.pr_hi);
    match     = &in_rng;
  end

endmodule

// File: rtl/lrm_pair_eval.sv
module lrm_pair_eval
  import lrm_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  key_t                 key,
  input  logic [PAIR_BITS-1:0] pair_bits,
  input  logic [1:0]           slot_en,
  input  logic [IDX_W-1:0]     base_idx,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx
);

  logic [1:0] raw;
  logic [1:0] qual;

  for (genvar g = 0; g < 2; g++) begin : g_rule
    lrm_rule_cmp u_cmp (
      .key   (key),
      .rule  (rule_t'(pair_bits[g*RULE_W +: RULE_W])),
      .match (raw[g])
    );
    assign qual[g] = raw[g] & slot_en[g];
  end

  // even rule has the lower index
  always_comb begin
    hit = |qual;
    if (qual[0])      idx = base_idx;
    else if (qual[1]) idx = base_idx | IDX_W'(1);
    else              idx = '1;
  end

endmodule

// File: rtl/leaf_range_matcher.sv
module leaf_range_matcher
  import lrm_pkg::*;
#(
  parameter int NUM_TREES = 3,
  parameter int ADDR_W    = 10,
  parameter int PAIR_W    = 7,
  parameter int RULE_BASE = 256
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic                        start,
  input  logic [IP_W-1:0]             key_src_ip,
  input  logic [IP_W-1:0]             key_dst_ip,
  input  logic [PORT_W-1:0]           key_src_port,
  input  logic [PORT_W-1:0]           key_dst_port,
  input  logic [PROTO_W-1:0]          key_proto,
  input  logic [NUM_TREES*ADDR_W-1:0] leaf_addr,
  input  logic [NUM_TREES-1:0]        tree_live,
  output logic                        busy,
  output logic                        done,
  output logic                        hit,
  output logic [PAIR_W:0]             rule_idx
);

  localparam int IDX_W  = PAIR_W + 1;
  localparam int TREE_W = (NUM_TREES > 1) ? $clog2(NUM_TREES) : 1;
  localparam int LEAF_W = 5 + 2 * PAIR_W;
  localparam logic [3:0] ST_LEAF_IN = 4'd1;
  localparam logic [3:0] ST_PAIR0   = 4'd6;
  localparam logic [3:0] ST_LAST    = 4'd9;
  localparam logic [TREE_W-1:0] LAST_TREE = TREE_W'(NUM_TREES - 1);

  // ---------------- state ----------------
  logic                        busy_q;
  logic [3:0]                  step_q;
  logic [TREE_W-1:0]           tree_q;
  key_t                        key_q;
  logic [NUM_TREES*ADDR_W-1:0] addrs_q;
  logic [NUM_TREES-1:0]        live_q;
  logic [LEAF_W-1:0]           leaf_q;
  logic [PAIR_BITS-1:0]        pair_q;
  logic                        c0_hit, best_hit, done_q, hit_q;
  logic [IDX_W-1:0]            c0_idx, best_idx, idx_q;

  logic [ADDR_W-1:0]           rd_addr;
  logic [WORD_W-1:0]           rd_data;

  lrm_ram #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // ---------------- leaf decode ----------------
  logic [1:0]        l_type;
  logic [2:0]        l_cnt, cnt_eff;
  logic [PAIR_W-1:0] l_p0, l_p1;
  logic              leaf_ok;
  logic [SLOTS-1:0]  slot_en;

  assign l_type  = leaf_q[1:0];
  assign l_cnt   = leaf_q[4:2];
  assign l_p0    = leaf_q[5 +: PAIR_W];
  assign l_p1    = leaf_q[5+PAIR_W +: PAIR_W];
  assign cnt_eff = (l_cnt > 3'd4) ? 3'd4 : l_cnt;
  assign leaf_ok = live_q[tree_q] && (l_type == LEAF_TYPE);

  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    assign slot_en[j] = leaf_ok && (3'(j) < cnt_eff);
  end

  // ---------------- read address sequence ----------------
  always_comb begin
    unique case (step_q)
      4'd0:                rd_addr = addrs_q[int'(tree_q)*ADDR_W +: ADDR_W];
      4'd2, 4'd3, 4'd4:    rd_addr = ADDR_W'(RULE_BASE + 3*int'(l_p0) + int'(step_q) - 2);
      4'd5, 4'd6, 4'd7:    rd_addr = ADDR_W'(RULE_BASE + 3*int'(l_p1) + int'(step_q) - 5);
      default:             rd_addr = '0;
    endcase
  end

  // ---------------- pair assembly: word k lands in slice k ----------------
  for (genvar k = 0; k < 3; k++) begin : g_word
    localparam int SL_W = (PAIR_BITS - k*WORD_W < WORD_W) ? (PAIR_BITS - k*WORD_W) : WORD_W;
    localparam logic [3:0] ST_A = 4'(3 + k);
    localparam logic [3:0] ST_B = 4'(6 + k);
    always_ff @(posedge clk) begin
      if (busy_q && (step_q == ST_A || step_q == ST_B))
        pair_q[k*WORD_W +: SL_W] <= rd_data[SL_W-1:0];
    end
  end

  // ---------------- rule evaluation ----------------
  logic             ev_hit;
  logic [IDX_W-1:0] ev_idx;
  logic             sel_second;

  assign sel_second = (step_q == ST_LAST);

  lrm_pair_eval #(.IDX_W(IDX_W)) u_eval (
    .key       (key_q),
    .pair_bits (pair_q),
    .slot_en   (sel_second ? slot_en[3:2] : slot_en[1:0]),
    .base_idx  (sel_second ? {l_p1, 1'b0} : {l_p0, 1'b0}),
    .hit       (ev_hit),
    .idx       (ev_idx)
  );

  function automatic logic [IDX_W:0] pick(input logic ah, input logic [IDX_W-1:0] ai,
                                           input logic bh, input logic [IDX_W-1:0] bi);
    if (ah && (!bh || ai <= bi)) return {1'b1, ai};
    else if (bh)                 return {1'b1, bi};
    else                         return {1'b0, {IDX_W{1'b1}}};
  endfunction

  logic [IDX_W:0] tree_res, merged;
  assign tree_res = pick(c0_hit, c0_idx, ev_hit, ev_idx);
  assign merged   = pick(best_hit, best_idx, tree_res[IDX_W], tree_res[IDX_W-1:0]);

  // ---------------- control ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      step_q   <= '0;
      tree_q   <= '0;
      key_q    <= '0;
      addrs_q  <= '0;
      live_q   <= '0;
      leaf_q   <= '0;
      c0_hit   <= 1'b0;
      c0_idx   <= '1;
      best_hit <= 1'b0;
      best_idx <= '1;
      done_q   <= 1'b0;
      hit_q    <= 1'b0;
      idx_q    <= '1;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q   <= 1'b1;
          step_q   <= '0;
          tree_q   <= '0;
          key_q    <= '{sip: key_src_ip, dip: key_dst_ip, sp: key_src_port,
                        dp: key_dst_port, pr: key_proto};
          addrs_q  <= leaf_addr;
          live_q   <= tree_live;
          best_hit <= 1'b0;
          best_idx <= '1;
        end
      end else begin
        if (step_q == ST_LEAF_IN) leaf_q <= rd_data[LEAF_W-1:0];
        if (step_q == ST_PAIR0) begin
          c0_hit <= ev_hit;
          c0_idx <= ev_idx;
        end
        if (step_q == ST_LAST) begin
          step_q <= '0;
          if (tree_q == LAST_TREE) begin
            hit_q  <= merged[IDX_W];
            idx_q  <= merged[IDX_W-1:0];
            done_q <= 1'b1;
            busy_q <= 1'b0;
          end else begin
            best_hit <= merged[IDX_W];
            best_idx <= merged[IDX_W-1:0];
            tree_q   <= tree_q + 1'b1;
          end
        end else begin
          step_q <= step_q + 4'd1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign hit      = hit_q;
  assign rule_idx = idx_q;

  // ---------------- assertions ----------------
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  p_hold_result_r11: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> ($stable(idx_q) && $stable(hit_q)));

  p_nomatch_code_r8: assert property (@(posedge clk) disable iff (rst)
    !hit_q |-> (idx_q == {IDX_W{1'b1}}));

  p_step_bound_r9: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (step_q <= ST_LAST));

  p_end_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> done_q);

  p_tree_bound_r7: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (int'(tree_q) < NUM_TREES));

  p_busy_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_q && step_q != ST_LAST) |=> busy_q);

endmodule

// File: tb/leaf_range_matcher_test.sv
module leaf_range_matcher_test;
  import lrm_pkg::*;

  localparam int NT = 3;
  localparam int AW = 10;
  localparam int PW = 7;
  localparam int RB = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [WORD_W-1:0] wr_data = '0;
  logic start = 1'b0;
  key_t kin = '0;
  logic [NT*AW-1:0] laddr = '0;
  logic [NT-1:0] live = '0;
  logic busy, done, hit;
  logic [PW:0] rule_idx;

  always #5 clk = ~clk;

  leaf_range_matcher #(.NUM_TREES(NT), .ADDR_W(AW), .PAIR_W(PW), .RULE_BASE(RB)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .key_src_ip(kin.sip), .key_dst_ip(kin.dip),
    .key_src_port(kin.sp), .key_dst_port(kin.dp), .key_proto(kin.pr),
    .leaf_addr(laddr), .tree_live(live), .busy(busy), .done(done), .hit(hit),
    .rule_idx(rule_idx)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- bench copy of the table ----------------
  localparam key_t K0 = '{sip: 32'h0A000005, dip: 32'hC0A80110, sp: 16'd1000,
                          dp: 16'd80, pr: 8'd6};

  rule_t rl [16];
  logic [1:0] lty [16];
  logic [2:0] lct [16];
  logic [PW-1:0] lpa [16];
  logic [PW-1:0] lpb [16];

  function automatic rule_t mk(input int mode);
    rule_t r;
    r.sip_lo = K0.sip - 32'd2; r.sip_hi = K0.sip + 32'd3;
    r.dip_lo = K0.dip - 32'd2; r.dip_hi = K0.dip + 32'd3;
    r.sp_lo  = K0.sp  - 16'd2; r.sp_hi  = K0.sp  + 16'd3;
    r.dp_lo  = K0.dp  - 16'd2; r.dp_hi  = K0.dp  + 16'd3;
    r.pr_lo  = K0.pr  - 8'd2;  r.pr_hi  = K0.pr  + 8'd3;
    case (mode)
      0: begin r.sip_lo = K0.sip + 32'd1; r.sip_hi = K0.sip + 32'd9; end
      1: begin r.dip_lo = K0.dip + 32'd1; r.dip_hi = K0.dip + 32'd9; end
      2: begin r.sp_lo  = K0.sp + 16'd1;  r.sp_hi  = K0.sp + 16'd9;  end
      3: begin r.dp_lo  = K0.dp + 16'd1;  r.dp_hi  = K0.dp + 16'd9;  end
      4: begin r.pr_lo  = K0.pr + 8'd1;   r.pr_hi  = K0.pr + 8'd9;   end
      5: begin r.dip_lo = K0.dip - 32'd5; r.dip_hi = K0.dip - 32'd1; end
      6: begin
        r.sip_lo = K0.sip; r.sip_hi = K0.sip; r.dip_lo = K0.dip; r.dip_hi = K0.dip;
        r.sp_lo = K0.sp; r.sp_hi = K0.sp; r.dp_lo = K0.dp; r.dp_hi = K0.dp;
        r.pr_lo = K0.pr; r.pr_hi = K0.pr;
      end
      default: ;
    endcase
    return r;
  endfunction

  function automatic bit rule_in(input key_t k, input rule_t r);
    return k.sip >= r.sip_lo && k.sip <= r.sip_hi && k.dip >= r.dip_lo && k.dip <= r.dip_hi &&
           k.sp >= r.sp_lo && k.sp <= r.sp_hi && k.dp >= r.dp_lo && k.dp <= r.dp_hi &&
           k.pr >= r.pr_lo && k.pr <= r.pr_hi;
  endfunction

  // reference: R2..R8 from the requirement text
  function automatic logic [8:0] model(input key_t k, input int a0, input int a1,
                                       input int a2, input logic [2:0] lv);
    int ad [3];
    int best = 256;
    ad[0] = a0; ad[1] = a1; ad[2] = a2;
    for (int t = 0; t < 3; t++) begin
      if (lv[t] && lty[ad[t]] == 2'b11) begin
        int n = (lct[ad[t]] > 3'd4) ? 4 : int'(lct[ad[t]]);
        for (int j = 0; j < n; j++) begin
          int r = 2 * int'((j < 2) ? lpa[ad[t]] : lpb[ad[t]]) + (j % 2);
          if (rule_in(k, rl[r]) && r < best) best = r;
        end
      end
    end
    if (best == 256) return {1'b0, 8'hFF};
    return {1'b1, 8'(best)};
  endfunction

  task automatic wr(input int a, input logic [WORD_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put_leaf(input int a, input logic [1:0] ty, input logic [2:0] ct,
                          input int pa, input int pb);
    lty[a] = ty; lct[a] = ct; lpa[a] = PW'(pa); lpb[a] = PW'(pb);
    wr(a, WORD_W'({PW'(pb), PW'(pa), ct, ty}));
  endtask

  // R5: pair p at RB+3p, low word first, even rule in low half
  task automatic put_pair(input int p);
    logic [3*WORD_W-1:0] ext;
    ext = (3*WORD_W)'({rl[2*p+1], rl[2*p]});
    for (int k = 0; k < 3; k++) wr(RB + 3*p + k, ext[k*WORD_W +: WORD_W]);
  endtask

  // ---------------- scoreboard ----------------
  typedef struct {
    logic       h;
    logic [7:0] i;
    int         sc;
    string      tag;
  } exp_t;
  exp_t q[$];

  task automatic run(input key_t k, input int a0, input int a1, input int a2,
                     input logic [2:0] lv, input string tag);
    logic [8:0] e;
    @(negedge clk);
    while (busy) @(negedge clk);
    e = model(k, a0, a1, a2, lv);
    kin = k; laddr = {AW'(a2), AW'(a1), AW'(a0)}; live = lv; start = 1'b1;
    q.push_back('{h: e[8], i: e[7:0], sc: cyc + 1, tag: tag});
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q.size() == 0) begin
        check(0, "R10", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(hit == e.h, e.tag, "hit", int'(hit), int'(e.h));
        check(rule_idx == e.i, e.tag, "rule_idx", int'(rule_idx), int'(e.i));
        check(cyc - e.sc == 10*NT, "R9", "latency", cyc - e.sc, 10*NT);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "WATCHDOG", "timeout", 0, 1);
    finish_run();
  end

  initial begin
    key_t k2;
    repeat (3) @(negedge clk);
    // R1 reset state while reset is held
    check(busy == 0, "R1", "busy", int'(busy), 0);
    check(done == 0, "R1", "done", int'(done), 0);
    check(hit == 0, "R1", "hit", int'(hit), 0);
    check(rule_idx == 8'hFF, "R1", "rule_idx", int'(rule_idx), 255);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0 && done == 0, "R1", "idle after reset", int'(busy), 0);

    // table: rule modes (0..4 miss a field low side, 5 miss high side, 6 exact, 7 match)
    rl[0] = mk(0); rl[1] = mk(7); rl[2] = mk(6); rl[3] = mk(7);
    rl[4] = mk(1); rl[5] = mk(7); rl[6] = mk(2); rl[7] = mk(7);
    rl[8] = mk(0); rl[9] = mk(1); rl[10] = mk(2); rl[11] = mk(3);
    rl[12] = mk(4); rl[13] = mk(5); rl[14] = mk(7); rl[15] = mk(7);
    for (int p = 0; p < 8; p++) put_pair(p);
    put_leaf(0, 2'b11, 3'd4, 0, 1);
    put_leaf(1, 2'b11, 3'd1, 0, 1);
    put_leaf(2, 2'b11, 3'd7, 0, 1);
    put_leaf(3, 2'b01, 3'd4, 0, 1);
    put_leaf(4, 2'b11, 3'd4, 2, 3);
    put_leaf(5, 2'b11, 3'd4, 6, 7);
    put_leaf(6, 2'b11, 3'd4, 4, 5);
    put_leaf(7, 2'b11, 3'd0, 0, 1);
    put_leaf(8, 2'b11, 3'd3, 1, 0);
    put_leaf(9, 2'b11, 3'd4, 3, 0);

    run(K0, 0, 7, 7, 3'b001, "R2");   // rule 0 misses, 1 wins
    run(K0, 1, 7, 7, 3'b001, "R4");   // only slot 0 used -> none
    run(K0, 2, 7, 7, 3'b001, "R4");   // count 7 behaves as 4
    run(K0, 3, 7, 7, 3'b001, "R3");   // wrong node type
    run(K0, 6, 7, 7, 3'b001, "R2");   // each field out of range
    run(K0, 5, 7, 7, 3'b001, "R2");   // proto and high-side misses, 14 wins
    run(K0, 7, 7, 7, 3'b111, "R8");   // count 0 everywhere
    run(K0, 8, 7, 7, 3'b001, "R3");   // swapped pairs, exact-boundary rule 2
    run(K0, 9, 7, 7, 3'b001, "R6");   // lower index in a later slot wins
    run(K0, 4, 5, 0, 3'b111, "R7");   // 5,14,1 -> 1
    run(K0, 4, 5, 0, 3'b011, "R7");   // tree 2 dead -> 5
    run(K0, 0, 5, 4, 3'b110, "R7");   // tree 0 dead -> 5
    k2 = K0; k2.sip = K0.sip + 32'd100;
    run(k2, 4, 5, 0, 3'b111, "R8");   // no rule covers this source

    // R10: a start while busy, with other inputs, is ignored
    run(K0, 0, 7, 7, 3'b001, "R10");
    repeat (5) @(negedge clk);
    kin = k2; laddr = {AW'(0), AW'(5), AW'(4)}; live = 3'b111; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy || q.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    // R11: result holds after the strobe
    check(hit == 1 && rule_idx == 8'd1, "R11", "held rule_idx", int'(rule_idx), 1);
    check(q.size() == 0, "R10", "pending results", q.size(), 0);
    finish_run();
  end

endmodule